// File: doc/BRIEF.md
# Carrier Sense and Collision Detector

This block generates the carrier-sense (CRS) and collision (COL) indications that a 10/100 Ethernet PHY presents to its MAC. At 100 Mb/s it watches the recovered, NRZI-decoded serial bit stream through a sliding 10-bit window. Receive activity begins when that window holds two or more zeros that are not just a single adjacent pair. Activity ends after ten consecutive ones. At 10 Mb/s, receive activity is taken directly from an unsquelched-activity flag.

Receive activity and the MAC's transmit enable are combined according to the duplex and repeater controls. In half duplex, CRS reports either direction of traffic. In full duplex and in repeater operation, CRS reports receive activity only. COL is held low in full duplex. In half-duplex 10 Mb/s operation, an end-of-transmit event starts a signal quality error (SQE) test pulse on COL after a programmable delay. A control bit can inhibit that pulse. Both outputs are registered on the block clock and make no claim to be aligned with the MII data clocks.

Top module: `crs_col_gen`

## Requirements
- R1: While the synchronous reset `rst` is high, `crs` and `col` are low at each clock edge. Reset returns the 100 Mb/s window to all ones and clears receive activity.
- R2: With `speed100`=0, receive activity equals `rx_act10`, and `crs` follows it one clock later. With `speed100`=1, `rx_act10` has no effect.
- R3: With `speed100`=1, each cycle with `rx_bit_vld`=1 shifts `rx_bit` into a 10-bit window, and cycles without the strobe leave the window unchanged. Receive activity starts when the window holds three or more zeros, or exactly two zeros that are not adjacent. Two zeros eleven bits apart never share the window. `crs` rises 3 clocks after the strobe cycle that completes the pattern.
- R4: At 100 Mb/s, receive activity ends when the window holds ten ones. `crs` falls 3 clocks after the tenth consecutive one is strobed in, and stays high until then.
- R5: With `full_dpx`=0 and `rptr_mode`=0, `crs` is high one clock after receive activity or `tx_en` is high.
- R6: With `full_dpx`=1 or `rptr_mode`=1, `crs` follows receive activity only, and `tx_en` has no effect on it.
- R7: With `full_dpx`=0, `col` is high one clock after receive activity and `tx_en` are both high. This holds in repeater mode too.
- R8: With `full_dpx`=1, `col` is low one clock later, whatever the other inputs are.
- R9: In 10 Mb/s half duplex with `sqe_inhibit`=0, a `tx_done` pulse sampled at clock edge e starts the SQE test. `col` is then high after edges e+SQE_DLY+1 through e+SQE_DLY+SQE_LEN, and low after the next edge. A `tx_done` that arrives while a test is already running is ignored.
- R10: No SQE test starts if `tx_done` is sampled while `sqe_inhibit`=1, `speed100`=1 or `full_dpx`=1.
- R11: `col` is the OR of the collision term and the SQE test pulse. A collision that overlaps the pulse keeps `col` high across the whole union.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| speed100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| full_dpx | input | 1 | 1 selects full duplex |
| rptr_mode | input | 1 | 1 selects repeater operation |
| sqe_inhibit | input | 1 | 1 suppresses the SQE test pulse |
| rx_bit | input | 1 | Decoded 100 Mb/s receive bit |
| rx_bit_vld | input | 1 | Strobe qualifying `rx_bit` |
| rx_act10 | input | 1 | Unsquelched 10 Mb/s receive activity |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_done | input | 1 | End-of-transmit event, one clock wide |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision / SQE test indication |

## Verification
The SQE test pulse and a genuine collision can drive `col` in the same cycles. The bench provokes this by raising transmit enable and 10 Mb/s receive activity partway through the pulse window, then dropping both before the pulse ends. It judges the result from expected `col` and `crs` values stamped at cycles inside the overlap, after the collision ends, and one cycle past the pulse. `col` must stay high over the whole union, while `crs` tracks only the traffic.

// File: rtl/crs_col_gen.sv
module crs_col_gen #(
  parameter int WIN_BITS = 10,
  parameter int SQE_DLY  = 16,
  parameter int SQE_LEN  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic speed100,
  input  logic full_dpx,
  input  logic rptr_mode,
  input  logic sqe_inhibit,
  input  logic rx_bit,
  input  logic rx_bit_vld,
  input  logic rx_act10,
  input  logic tx_en,
  input  logic tx_done,
  output logic crs,
  output logic col
);
  localparam int ZW   = $clog2(WIN_BITS + 1);
  localparam int CMAX = (SQE_DLY > SQE_LEN) ? SQE_DLY : SQE_LEN;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_PULSE} sq_t;

  logic [WIN_BITS-1:0] win;
  logic [ZW-1:0]       nz;
  logic                act100, rx_act, hit, sqe_on, arm;
  logic [CW-1:0]       cnt;
  sq_t                 st;

  wire [WIN_BITS-1:0] zeros = ~win;
  wire adj  = |(zeros & (zeros >> 1));
  wire idle = &win;

  always_comb begin
    nz = '0;
    for (int i = 0; i < WIN_BITS; i++) nz = nz + ZW'(zeros[i]);
  end

  assign hit    = (nz >= ZW'(3)) || (nz == ZW'(2) && !adj);
  assign rx_act = speed100 ? act100 : rx_act10;
  assign sqe_on = (st == SQ_PULSE);
  assign arm    = tx_done && !full_dpx && !speed100 && !sqe_inhibit;

  always_ff @(posedge clk) begin
    if (rst) begin
      win    <= '1;
      act100 <= 1'b0;
    end else begin
      if (rx_bit_vld) win <= {win[WIN_BITS-2:0], rx_bit};
      if (hit)       act100 <= 1'b1;
      else if (idle) act100 <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (arm) begin
          st  <= SQ_WAIT;
          cnt <= CW'(SQE_DLY - 1);
        end
        SQ_WAIT: if (cnt == '0) begin
          st  <= SQ_PULSE;
          cnt <= CW'(SQE_LEN - 1);
        end else cnt <= cnt - 1'b1;
        SQ_PULSE: if (cnt == '0) st <= SQ_IDLE;
                  else cnt <= cnt - 1'b1;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crs <= 1'b0;
      col <= 1'b0;
    end else begin
      crs <= (full_dpx || rptr_mode) ? rx_act : (rx_act || tx_en);
      col <= !full_dpx && ((rx_act && tx_en) || sqe_on);
    end
  end

  logic [CW:0] chk_len;
  always_ff @(posedge clk) begin
    if (rst || !sqe_on) chk_len <= '0;
    else                chk_len <= chk_len + 1'b1;
  end

  assert_reset_low_R1: assert property (@(posedge clk) $past(rst) |-> (!crs && !col));
  assert_idle_end_R4: assert property (@(posedge clk) disable iff (rst)
    (act100 && idle && !hit) |=> !act100);
  assert_half_crs_R5: assert property (@(posedge clk) disable iff (rst)
    (!full_dpx && !rptr_mode && tx_en) |=> crs);
  assert_collision_R7: assert property (@(posedge clk) disable iff (rst)
    (!full_dpx && tx_en && rx_act) |=> col);
  assert_fdx_col_low_R8: assert property (@(posedge clk) disable iff (rst)
    full_dpx |=> !col);
  assert_pulse_len_R9: assert property (@(posedge clk) disable iff (rst)
    sqe_on |-> (chk_len < (CW+1)'(SQE_LEN)));
  assert_sqe_or_R11: assert property (@(posedge clk) disable iff (rst)
    (!full_dpx && sqe_on) |=> col);
endmodule

// File: tb/test_crs_col_gen.sv
module test_crs_col_gen;
  logic clk = 1'b0;
  logic rst, speed100, full_dpx, rptr_mode, sqe_inhibit;
  logic rx_bit, rx_bit_vld, rx_act10, tx_en, tx_done;
  logic crs, col;
  int   cyc = 0, checks = 0, failures = 0;
  int   q_cyc[$];
  logic [1:0] q_val[$];
  string q_tag[$];

  always #2 clk = ~clk;

  crs_col_gen i_crs_col_gen (
    .clk(clk), .rst(rst), .speed100(speed100), .full_dpx(full_dpx),
    .rptr_mode(rptr_mode), .sqe_inhibit(sqe_inhibit), .rx_bit(rx_bit),
    .rx_bit_vld(rx_bit_vld), .rx_act10(rx_act10), .tx_en(tx_en),
    .tx_done(tx_done), .crs(crs), .col(col));

  task automatic expect_at(int d, logic c, logic l, string tag);
    q_cyc.push_back(cyc + d);
    q_val.push_back({c, l});
    q_tag.push_back(tag);
  endtask

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic bit100(logic b);
    rx_bit = b; rx_bit_vld = 1'b1; step(1);
  endtask

  task automatic ones(int k);
    for (int i = 0; i < k; i++) bit100(1'b1);
  endtask

  always begin
    @(posedge clk);
    cyc++;
    #1;
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      checks++;
      if (q_cyc[0] < cyc || q_val[0] !== {crs, col}) begin
        failures++;
        $display("FAIL %s at cycle %0d: crs/col actual=%b%b expected=%b", q_tag[0], cyc, crs, col, q_val[0]);
      end
      void'(q_cyc.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1; speed100 = 0; full_dpx = 0; rptr_mode = 0; sqe_inhibit = 0;
    rx_bit = 1; rx_bit_vld = 0; rx_act10 = 0; tx_en = 0; tx_done = 0;
    step(1);
    rx_act10 = 1; tx_en = 1;
    expect_at(1, 0, 0, "R1 reset holds outputs low");
    step(3);
    rx_act10 = 0; tx_en = 0; rst = 0; step(2);

    rx_act10 = 1; expect_at(1, 1, 0, "R2 R5 crs from 10M rx"); step(2);
    tx_en = 1;    expect_at(1, 1, 1, "R7 collision half duplex"); step(2);
    rx_act10 = 0; expect_at(1, 1, 0, "R5 crs from tx"); step(2);
    tx_en = 0;    expect_at(1, 0, 0, "R5 idle"); step(2);

    full_dpx = 1; tx_en = 1; rx_act10 = 1;
    expect_at(1, 1, 0, "R8 col low in full duplex"); step(2);
    rx_act10 = 0; expect_at(1, 0, 0, "R6 full duplex ignores tx"); step(2);
    full_dpx = 0; rptr_mode = 1;
    expect_at(1, 0, 0, "R6 repeater ignores tx"); step(2);
    rx_act10 = 1; expect_at(1, 1, 1, "R7 collision in repeater"); step(2);
    rx_act10 = 0; tx_en = 0; rptr_mode = 0; step(2);

    expect_at(17, 0, 0, "R9 sqe not yet");
    expect_at(18, 0, 1, "R9 sqe pulse start");
    expect_at(27, 0, 1, "R9 sqe pulse last");
    expect_at(28, 0, 0, "R9 sqe pulse end");
    tx_done = 1; step(1); tx_done = 0; step(30);

    sqe_inhibit = 1;
    expect_at(18, 0, 0, "R10 inhibit start"); expect_at(22, 0, 0, "R10 inhibit mid");
    tx_done = 1; step(1); tx_done = 0; step(30);
    sqe_inhibit = 0; speed100 = 1;
    expect_at(18, 0, 0, "R10 no sqe at 100M"); expect_at(22, 0, 0, "R10 no sqe at 100M mid");
    tx_done = 1; step(1); tx_done = 0; step(30);
    speed100 = 0; full_dpx = 1;
    expect_at(18, 0, 0, "R10 no sqe in full duplex");
    tx_done = 1; step(1); tx_done = 0; step(30);
    full_dpx = 0;

    expect_at(18, 0, 1, "R11 pulse before collision");
    expect_at(22, 1, 1, "R11 overlap");
    expect_at(26, 0, 1, "R11 pulse after collision");
    expect_at(28, 0, 0, "R11 all quiet");
    tx_done = 1; step(1); tx_done = 0; step(19);
    tx_en = 1; rx_act10 = 1; step(4);
    tx_en = 0; rx_act10 = 0; step(8);

    speed100 = 1;
    rx_act10 = 1;
    expect_at(1, 0, 0, "R2 rx_act10 ignored at 100M");
    expect_at(3, 0, 0, "R2 rx_act10 ignored at 100M later");
    step(4); rx_act10 = 0;

    rx_bit = 0; rx_bit_vld = 0;
    expect_at(3, 0, 0, "R3 no strobe no shift");
    expect_at(6, 0, 0, "R3 no strobe no shift later");
    step(6); rx_bit = 1;

    ones(5); bit100(0); bit100(1);
    expect_at(2, 0, 0, "R3 detect not yet");
    expect_at(3, 1, 0, "R3 two split zeros");
    bit100(0);
    ones(9);
    expect_at(2, 1, 0, "R4 carrier held");
    expect_at(3, 0, 0, "R4 ten ones end carrier");
    bit100(1); ones(4);

    bit100(0);
    expect_at(3, 0, 0, "R3 adjacent pair no carrier");
    bit100(0); ones(12);
    bit100(0); ones(9);
    expect_at(3, 0, 0, "R3 zeros eleven apart");
    bit100(0); ones(12);
    bit100(0); ones(8);
    expect_at(3, 1, 0, "R3 zeros ten apart");
    bit100(0); ones(13);
    expect_at(1, 0, 0, "R4 idle after span ten");
    step(2);
    bit100(0); bit100(0);
    expect_at(3, 1, 0, "R3 three zeros");
    bit100(0); ones(13);

    tx_en = 1; bit100(0); bit100(1);
    expect_at(3, 1, 1, "R7 collision at 100M");
    bit100(0); ones(3); tx_en = 0; ones(10); step(4);

    if (q_cyc.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", q_cyc.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule